// File: doc/BRIEF.md
# System Address Decoder with Firmware Shadowing and Protected Region

This block sorts every memory request on a 32-bit address bus into one of three destinations: main DRAM, the downstream I/O port, or the interrupt-controller target. It is used at the root of a host memory path. The request carries the address, a write flag and a flag that marks system-management mode. One cycle after a valid request, the block presents a registered target code and a strobe.

Several settings are held in a small write-only register interface. The first is a pair of attributes for the 64 KB upper firmware window. Reads and writes to that window follow separate enables, so firmware can be read from the I/O port while it is written into DRAM (shadowing). The second is the top of low memory, in megabyte units. The third is a protected region with a base, a size and an enable. A request outside system-management mode that would reach DRAM inside that region is sent to the I/O port instead and flagged as blocked.

Target codes are: 0 = DRAM, 1 = I/O port, 2 = interrupt target.

Top module: `sys_addr_decoder`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_target` and `rsp_blocked` give the decode of that request and hold until the next one.
- R2: After reset, both firmware window enables are off, the top of low memory is 2048 MB, and the protected region is disabled. Reads and writes to 0x000F_0000..0x000F_FFFF then go to the I/O port (code 1).
- R3: In the window 0x000F_0000..0x000F_FFFF, reads go to DRAM when config select 0 bit 0 is set and to the I/O port otherwise. Writes do the same under bit 1. The two enables act independently.
- R4: Addresses below 0x000F_0000 decode to DRAM.
- R5: Addresses from 0x0010_0000 up to, but not including, the top of low memory decode to DRAM. This includes 0x00F0_0000..0x00FF_FFFF. The top of low memory is written through select 1, bits [12:0], in MB.
- R6: A top-of-low-memory write above 4096 MB is stored as 4096 MB. All non-interrupt addresses from 1 MB upward then go to DRAM.
- R7: 0xFEC0_0000..0xFECF_FFFF and 0xFEE0_0000..0xFEEF_FFFF always decode to the interrupt target (code 2), whatever the top of low memory is.
- R8: Addresses from the top of low memory up to 4 GB that are not in the interrupt ranges decode to the I/O port (code 1).
- R9: The protected region is set by select 2 bits [11:0] (base, in MB), select 3 bits [12:0] (size, in MB) and select 3 bit 31 (enable). It covers megabyte numbers from base up to, but not including, base+size. When it is enabled, a request without the SMM flag that would decode to DRAM inside it goes to the I/O port with `rsp_blocked` high. The same request with the SMM flag goes to DRAM with `rsp_blocked` low. When it is disabled, nothing is blocked.
- R10: A register write takes effect for requests from the next cycle on. A request in the same cycle as the write decodes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 window enables, 1 top of memory, 2 region base, 3 region size/enable) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Request issued in system-management mode |
| rsp_valid | output | 1 | Decode result strobe |
| rsp_target | output | 2 | Destination code |
| rsp_blocked | output | 1 | Protected-region access refused |

## Verification
The assertions assume that reset is held from time zero until the first clock edges. They also assume that `req_addr`, `req_write` and `req_smm` are meaningful only while `req_valid` is high, so every property that looks back to a request is gated on the past strobe. The stimulus drives all inputs on falling edges and keeps the strobes low during reset. It holds one request pulse per check, with idle cycles between them, so each registered result can be tied to exactly one request.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;

    localparam int ADDR_W   = 32;
    localparam int MB_W     = ADDR_W - 20;
    localparam int TOLM_W   = MB_W + 1;
    localparam int SIZE_W   = MB_W + 1;
    localparam int DATA_W   = 32;

    localparam logic [TOLM_W-1:0] TOLM_MAX = TOLM_W'(1) << MB_W;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IO   = 2'd1,
        TGT_IRQ  = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        SEL_FWWIN = 2'd0,
        SEL_TOLM  = 2'd1,
        SEL_PBASE = 2'd2,
        SEL_PSIZE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              fw_rd_en;
        logic              fw_wr_en;
        logic [TOLM_W-1:0] tolm_mb;
        logic [MB_W-1:0]   prot_base;
        logic [SIZE_W-1:0] prot_size;
        logic              prot_en;
    } cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              smm;
    } req_t;

    typedef struct packed {
        target_e target;
        logic    blocked;
    } dec_t;

    function automatic logic is_irq(input logic [ADDR_W-1:0] a);
        return (a[31:20] == 12'hFEC) || (a[31:20] == 12'hFEE);
    endfunction

    function automatic logic is_fw_window(input logic [ADDR_W-1:0] a);
        return (a[31:16] == 16'h000F);
    endfunction

    function automatic logic [TOLM_W-1:0] clamp_tolm(input logic [DATA_W-1:0] d);
        logic [TOLM_W-1:0] v;
        v = d[TOLM_W-1:0];
        return (v > TOLM_MAX) ? TOLM_MAX : v;
    endfunction

endpackage

// File: rtl/sysdec_cfg.sv
module sysdec_cfg
    import sysdec_pkg::*;
#(
    parameter int TOLM_RESET_MB = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);

    localparam logic [TOLM_W-1:0] TOLM_RST = TOLM_W'(TOLM_RESET_MB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.fw_rd_en  <= 1'b0;
            cfg.fw_wr_en  <= 1'b0;
            cfg.tolm_mb   <= TOLM_RST;
            cfg.prot_base <= '0;
            cfg.prot_size <= '0;
            cfg.prot_en   <= 1'b0;
        end else if (we) begin
            unique case (cfg_sel_e'(sel))
                SEL_FWWIN: begin
                    cfg.fw_rd_en <= wdata[0];
                    cfg.fw_wr_en <= wdata[1];
                end
                SEL_TOLM:  cfg.tolm_mb   <= clamp_tolm(wdata);
                SEL_PBASE: cfg.prot_base <= wdata[MB_W-1:0];
                SEL_PSIZE: begin
                    cfg.prot_size <= wdata[SIZE_W-1:0];
                    cfg.prot_en   <= wdata[31];
                end
                default: ;
            endcase
        end
    end

    // R6
    tolm_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.tolm_mb <= TOLM_MAX);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(cfg));

endmodule

// File: rtl/sysdec_route.sv
module sysdec_route
    import sysdec_pkg::*;
(
    input  req_t req,
    input  cfg_t cfg,
    output dec_t dec
);

    logic [MB_W-1:0]   mb;
    logic [SIZE_W:0]   prot_end;
    logic              prot_hit;
    target_e           base_tgt;

    assign mb       = req.addr[ADDR_W-1:20];
    assign prot_end = {2'b00, cfg.prot_base} + {1'b0, cfg.prot_size};
    assign prot_hit = cfg.prot_en
                    && ({2'b00, mb} >= {2'b00, cfg.prot_base})
                    && ({2'b00, mb} <  prot_end);

    always_comb begin
        if (is_irq(req.addr)) begin
            base_tgt = TGT_IRQ;
        end else if (is_fw_window(req.addr)) begin
            if (req.write) base_tgt = cfg.fw_wr_en ? TGT_DRAM : TGT_IO;
            else           base_tgt = cfg.fw_rd_en ? TGT_DRAM : TGT_IO;
        end else if (mb == '0) begin
            base_tgt = TGT_DRAM;
        end else if ({1'b0, mb} < cfg.tolm_mb) begin
            base_tgt = TGT_DRAM;
        end else begin
            base_tgt = TGT_IO;
        end
    end

    always_comb begin
        dec.target  = base_tgt;
        dec.blocked = 1'b0;
        if (base_tgt == TGT_DRAM && prot_hit && !req.smm) begin
            dec.target  = TGT_IO;
            dec.blocked = 1'b1;
        end
    end

    // R7
    irq_route_chk: assert final (!is_irq(req.addr) || dec.target == TGT_IRQ);

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
    import sysdec_pkg::*;
#(
    parameter int TOLM_RESET_MB = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic              rsp_blocked
);

    cfg_t cfg;
    req_t req;
    dec_t dec;
    dec_t dec_q;

    assign req = '{addr: req_addr, write: req_write, smm: req_smm};

    sysdec_cfg #(.TOLM_RESET_MB(TOLM_RESET_MB)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    sysdec_route u_route (
        .req (req),
        .cfg (cfg),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            dec_q     <= '{target: TGT_DRAM, blocked: 1'b0};
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) dec_q <= dec;
        end
    end

    assign rsp_target  = dec_q.target;
    assign rsp_blocked = dec_q.blocked;

    // R1
    rsp_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid));

    // R1
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> ($stable(rsp_target) && $stable(rsp_blocked)));

    // R9
    blocked_io_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_blocked |-> rsp_target == TGT_IO);

    // R9
    smm_never_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && $past(req_smm)) |-> !rsp_blocked);

    // R7
    irq_out_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && $past(is_irq(req_addr))) |-> rsp_target == TGT_IRQ);

    // R1
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_target != 2'd3);

endmodule

// File: tb/sys_addr_decoder_test.sv
module sys_addr_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic        rsp_blocked;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] T_DRAM = 2'd0;
    localparam logic [1:0] T_IO   = 2'd1;
    localparam logic [1:0] T_IRQ  = 2'd2;

    sys_addr_decoder uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_smm(req_smm), .rsp_valid(rsp_valid),
        .rsp_target(rsp_target), .rsp_blocked(rsp_blocked)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic wr,
                          input logic smm, input logic [1:0] tgt, input logic blk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " target"}, 32'(rsp_target), 32'(tgt));
        check({req, " blocked"}, 32'(rsp_blocked), 32'(blk));
        @(negedge clk);
        check({req, " strobe drop"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R2 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R2 reset blocked", 32'(rsp_blocked), 32'd0);
        access("R2 fw read default", 32'h000F_0000, 1'b0, 1'b0, T_IO, 1'b0);
        access("R2 fw write default", 32'h000F_FFFF, 1'b1, 1'b0, T_IO, 1'b0);
        access("R2 tolm reset below", 32'h7FF0_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R2 tolm reset at", 32'h8000_0000, 1'b0, 1'b0, T_IO, 1'b0);
    endtask

    task automatic t_shadow();
        cfg_write(2'd0, 32'h2);
        access("R3 shadow write", 32'h000F_8000, 1'b1, 1'b0, T_DRAM, 1'b0);
        access("R3 shadow read", 32'h000F_8000, 1'b0, 1'b0, T_IO, 1'b0);
        cfg_write(2'd0, 32'h1);
        access("R3 read only read", 32'h000F_0010, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R3 read only write", 32'h000F_0010, 1'b1, 1'b0, T_IO, 1'b0);
        cfg_write(2'd0, 32'h3);
        access("R3 both write", 32'h000F_FFF0, 1'b1, 1'b0, T_DRAM, 1'b0);
        cfg_write(2'd0, 32'h0);
        access("R3 off read", 32'h000F_FFF0, 1'b0, 1'b0, T_IO, 1'b0);
    endtask

    task automatic t_low();
        access("R4 below window", 32'h000E_FFFF, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R4 zero", 32'h0000_0000, 1'b1, 1'b0, T_DRAM, 1'b0);
    endtask

    task automatic t_tolm();
        cfg_write(2'd1, 32'd512);
        access("R5 first MB", 32'h0010_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R5 15-16MB hole", 32'h00F8_0000, 1'b1, 1'b0, T_DRAM, 1'b0);
        access("R5 last below tolm", 32'h1FFF_FFFF, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R8 at tolm", 32'h2000_0000, 1'b0, 1'b0, T_IO, 1'b0);
        access("R8 pci high", 32'hFED0_0000, 1'b1, 1'b0, T_IO, 1'b0);
        access("R7 irq low range", 32'hFEC0_1234, 1'b0, 1'b0, T_IRQ, 1'b0);
        cfg_write(2'd1, 32'd8000);
        access("R6 saturated top", 32'hFFF0_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R6 saturated mid", 32'hFED0_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R7 irq high range", 32'hFEEF_FFFF, 1'b1, 1'b0, T_IRQ, 1'b0);
        access("R7 irq low end", 32'hFECF_FFFF, 1'b0, 1'b0, T_IRQ, 1'b0);
        cfg_write(2'd1, 32'd2048);
    endtask

    task automatic t_prot();
        cfg_write(2'd2, 32'd256);
        cfg_write(2'd3, 32'h8000_0010);
        access("R9 non-smm blocked", 32'h1000_0000, 1'b0, 1'b0, T_IO, 1'b1);
        access("R9 non-smm blocked top", 32'h10FF_FFFF, 1'b1, 1'b0, T_IO, 1'b1);
        access("R9 smm allowed", 32'h1000_0000, 1'b0, 1'b1, T_DRAM, 1'b0);
        access("R9 just below", 32'h0FFF_FFFF, 1'b0, 1'b0, T_DRAM, 1'b0);
        access("R9 at end", 32'h1100_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
        cfg_write(2'd3, 32'h0000_0010);
        access("R9 disabled", 32'h1000_0000, 1'b0, 1'b0, T_DRAM, 1'b0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'd64;
        req_valid = 1'b1; req_addr = 32'h0800_0000; req_write = 1'b0; req_smm = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R10 old value in write cycle", 32'(rsp_target), 32'(T_DRAM));
        access("R10 new value next request", 32'h0800_0000, 1'b0, 1'b0, T_IO, 1'b0);
        cfg_write(2'd1, 32'd2048);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        check("R1 idle no strobe", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_shadow();
        t_low();
        t_tolm();
        t_prot();
        t_same_cycle();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule